// File: doc/BRIEF.md
# Reference-Selectable Clock Divider Path

This block is the digital clock path of a zero-delay clock generator. It picks one of two reference clocks, and then picks either that reference (bypass) or a VCO clock that arrives on a port. The chosen clock drives a power-of-two counter. The divide ratio comes from a 4-bit code, and the code is decoded through one of two tables. The bypass setting picks which table. Four identical outputs carry the divided clock.

The phase detector, loop filter and oscillator are outside this block, so the VCO is only an input clock here. In the oscillator setting, the divider applied to the VCO is chosen so that the oscillator sits in a 250 to 500 MHz band for the reference range that matches each code. The output-to-reference ratio listed for each code then follows from that choice. A change of selection is registered at the end of the output period that is running, and the registered copy steers the source multiplexer. Only whole periods ever appear on the outputs.

Top module: `refclk_divpath`

## Requirements
- R1: With the oscillator path off, `ref_sel` high routes `ref1_clk` to the divider and `ref_sel` low routes `ref0_clk`.
- R2: With `pll_en` high, `vco_clk` feeds the divider and `ref_sel` has no effect on the outputs. With `pll_en` low, the selected reference feeds the divider.
- R3: In bypass, `div_code` values 0 to 15 divide the reference by 8, 8, 8, 16, 16, 16, 32, 32, 64, 128, 4, 4, 8, 2, 4, 2 respectively.
- R4: In oscillator mode, `div_code` values 0 to 15 divide `vco_clk` by 2, 4, 8, 16, 4, 8, 16, 8, 16, 16, 2, 4, 8, 2, 4, 2. With the VCO at 2, 4, 8 or 16 times a reference in the code's band, this gives output/reference ratios of 1, 1, 1, 1, 1/2, 1/2, 1/2, 1/4, 1/4, 1/8, 2, 2, 2, 4, 4, 8.
- R5: Each output is high for exactly half of the divide count in source-clock cycles and low for the other half, which gives a 50% duty cycle.
- R6: `mrst_n` is an active-low reset that is synchronous to the selected clock. While it is low, all outputs are low from the next source edge onward. After release, the first source edge starts a new period with a rising output.
- R7: All four bits of `clk_out` carry the same waveform at all times.
- R8: A change of `div_code`, `ref_sel` or `pll_en` takes effect only at the end of the output period that is running. The old period completes in full and no shortened pulse appears.
- R9: The only divide values used are 2, 4, 8, 16, 32, 64 and 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref0_clk | input | 1 | First reference clock |
| ref1_clk | input | 1 | Second reference clock |
| vco_clk | input | 1 | Oscillator clock used when `pll_en` is high |
| mrst_n | input | 1 | Active-low master reset, synchronous to the selected clock |
| ref_sel | input | 1 | Reference choice: 1 selects `ref1_clk` |
| pll_en | input | 1 | Source choice: 1 selects `vco_clk`, 0 selects bypass |
| div_code | input | 4 | Divide-ratio code, decoded by the mode's table |
| clk_out | output | 4 | Four copies of the divided clock |

## Verification
The assertions run on every edge of the selected clock. They check that the four outputs agree, that reset pulls them low, that the registered divide exponent stays between 1 and 7, and that every high or low phase lasts exactly half the divide count that was loaded when the phase began. This last check also covers the no-runt rule across changes of ratio and source. Only the bench scenarios can show that each code maps to the tabulated period for the right source clock, that `ref_sel` is ignored in oscillator mode, and that a mid-period change leaves the old period intact in absolute time.

// File: rtl/refclk_divpath_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the two divide-ratio decode tables.
// Assumes a 4-bit code; ratios are stored as base-2 exponents (1..7).
package refclk_divpath_pkg;

    localparam int CODE_W  = 4;
    localparam int EXP_W   = 3;
    localparam int MAX_EXP = 7;

    // Bypass table: exponent of the reference divider for each code.
    function automatic logic [EXP_W-1:0] bypass_exp(input logic [CODE_W-1:0] code);
        logic [EXP_W-1:0] e;
        case (code)
            4'd0, 4'd1, 4'd2:   e = 3'd3;
            4'd3, 4'd4, 4'd5:   e = 3'd4;
            4'd6, 4'd7:         e = 3'd5;
            4'd8:               e = 3'd6;
            4'd9:               e = 3'd7;
            4'd10, 4'd11, 4'd14: e = 3'd2;
            4'd12:              e = 3'd3;
            default:            e = 3'd1; // codes 13 and 15
        endcase
        return e;
    endfunction

    // Oscillator table: exponent of the VCO divider for each code.
    function automatic logic [EXP_W-1:0] vco_exp(input logic [CODE_W-1:0] code);
        logic [EXP_W-1:0] e;
        case (code)
            4'd0, 4'd10, 4'd13, 4'd15: e = 3'd1;
            4'd1, 4'd4, 4'd11, 4'd14:  e = 3'd2;
            4'd2, 4'd5, 4'd7, 4'd12:   e = 3'd3;
            default:                   e = 3'd4; // codes 3, 6, 8, 9
        endcase
        return e;
    endfunction

endpackage

// File: rtl/refclk_div_decode.sv
`timescale 1ns/1ps
// Module: refclk_div_decode
// Turns the divide code into a base-2 exponent using the table of the
// current mode. Purely combinational; assumes CODE_W matches the tables.
module refclk_div_decode
    import refclk_divpath_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int XW    = EXP_W
) (
    input  logic [SEL_W-1:0] code,
    input  logic             pll_on,
    output logic [XW-1:0]    exp_o
);

    // Table lookup for the selected mode.
    always_comb begin
        if (pll_on) exp_o = XW'(vco_exp(CODE_W'(code)));
        else        exp_o = XW'(bypass_exp(CODE_W'(code)));
    end

endmodule

// File: rtl/refclk_src_mux.sv
`timescale 1ns/1ps
// Module: refclk_src_mux
// Two-level clock selection: reference pick, then reference or VCO.
// Assumes the select inputs only change right after a rising edge of
// the clock currently selected (the divider guarantees this).
module refclk_src_mux (
    input  logic ref0_i,
    input  logic ref1_i,
    input  logic vco_i,
    input  logic use_ref1,
    input  logic use_vco,
    output logic clk_o
);

    logic ref_pick;

    // First level: choose one of the references.
    always_comb ref_pick = use_ref1 ? ref1_i : ref0_i;

    // Second level: choose the reference or the oscillator.
    always_comb clk_o = use_vco ? vco_i : ref_pick;

endmodule

// File: rtl/refclk_div_counter.sv
`timescale 1ns/1ps
// Module: refclk_div_counter
// Power-of-two down-counter that produces NUM_OUT copies of a 50% duty
// clock. It loads the live configuration only when a period wraps, so
// each period runs to completion. Reset is synchronous and active-low.
module refclk_div_counter #(
    parameter int NUM_OUT = 4,
    parameter int MAX_EXP = 7,
    parameter int XW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XW-1:0]      exp_live,
    input  logic               ref_live,
    input  logic               vco_live,
    output logic [XW-1:0]      exp_q,
    output logic               ref_q,
    output logic               vco_q,
    output logic [NUM_OUT-1:0] q
);

    localparam int CNT_W  = MAX_EXP;
    localparam int SPAN_W = CNT_W + 1;

    logic [SPAN_W-1:0] span_live, span_cur;
    logic [CNT_W-1:0]  last_live, half_cur, cnt_q, cnt_dec;
    logic              wrap, phase_hi;

    // Period length of the incoming and the active configuration.
    always_comb begin
        span_live = SPAN_W'(1) << exp_live;
        span_cur  = SPAN_W'(1) << exp_q;
        last_live = CNT_W'(span_live - SPAN_W'(1));
        half_cur  = CNT_W'(span_cur >> 1);
    end

    // Wrap detect and next output level.
    always_comb begin
        cnt_dec  = cnt_q - CNT_W'(1);
        wrap     = (cnt_q == '0);
        phase_hi = (cnt_dec >= half_cur);
    end

    // Counter and configuration capture at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= exp_live;
            ref_q <= ref_live;
            vco_q <= vco_live;
        end else if (wrap) begin
            cnt_q <= last_live;
            exp_q <= exp_live;
            ref_q <= ref_live;
            vco_q <= vco_live;
        end else begin
            cnt_q <= cnt_dec;
        end
    end

    // One output flop per copy, all fed by the same next level.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (!rst_n)    q[i] <= 1'b0;
            else if (wrap) q[i] <= 1'b1;
            else           q[i] <= phase_hi;
        end
    end

endmodule

// File: rtl/refclk_divpath.sv
`timescale 1ns/1ps
// Module: refclk_divpath (top)
// Clock path of a zero-delay generator: reference select, bypass/VCO
// select, table decode and a divider with four identical outputs.
// During reset the source follows the live selects; afterwards it
// follows the copy that the divider registered at the last wrap.
module refclk_divpath
    import refclk_divpath_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = CODE_W,
    parameter int XW      = EXP_W,
    parameter int DIV_MAX = MAX_EXP
) (
    input  logic               ref0_clk,
    input  logic               ref1_clk,
    input  logic               vco_clk,
    input  logic               mrst_n,
    input  logic               ref_sel,
    input  logic               pll_en,
    input  logic [SEL_W-1:0]   div_code,
    output logic [NUM_OUT-1:0] clk_out
);

    logic          div_clk;
    logic          use_ref1, use_vco;
    logic          cfg_ref, cfg_vco;
    logic [XW-1:0] exp_live, cfg_exp;

    // Source selects: live under reset, registered otherwise.
    always_comb begin
        use_ref1 = mrst_n ? cfg_ref : ref_sel;
        use_vco  = mrst_n ? cfg_vco : pll_en;
    end

    refclk_src_mux u_mux (
        .ref0_i   (ref0_clk),
        .ref1_i   (ref1_clk),
        .vco_i    (vco_clk),
        .use_ref1 (use_ref1),
        .use_vco  (use_vco),
        .clk_o    (div_clk)
    );

    refclk_div_decode #(.SEL_W(SEL_W), .XW(XW)) u_dec (
        .code   (div_code),
        .pll_on (pll_en),
        .exp_o  (exp_live)
    );

    refclk_div_counter #(.NUM_OUT(NUM_OUT), .MAX_EXP(DIV_MAX), .XW(XW)) u_div (
        .clk      (div_clk),
        .rst_n    (mrst_n),
        .exp_live (exp_live),
        .ref_live (ref_sel),
        .vco_live (pll_en),
        .exp_q    (cfg_exp),
        .ref_q    (cfg_ref),
        .vco_q    (cfg_vco),
        .q        (clk_out)
    );

endmodule

// File: rtl/refclk_divpath_chk.sv
`timescale 1ns/1ps
// Module: refclk_divpath_chk
// Assertion checker bound to the top. It measures the length of each
// output phase in selected-clock cycles with its own counter.
module refclk_divpath_chk #(
    parameter int NUM_OUT = 4,
    parameter int XW      = 3,
    parameter int DIV_MAX = 7
) (
    input logic               clk,
    input logic               mrst_n,
    input logic [NUM_OUT-1:0] q,
    input logic [XW-1:0]      exp_cur
);

    logic             q_d, armed;
    logic [DIV_MAX:0] run_len, phase_half, half_now;

    // Half period implied by the registered exponent.
    always_comb half_now = ((DIV_MAX+1)'(1) << exp_cur) >> 1;

    // Track run length and the half period in force when the phase began.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            q_d        <= 1'b0;
            armed      <= 1'b0;
            run_len    <= '0;
            phase_half <= '0;
        end else begin
            q_d <= q[0];
            if (q[0] != q_d) begin
                run_len    <= (DIV_MAX+1)'(1);
                phase_half <= half_now;
                armed      <= 1'b1;
            end else begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // R7: every copy matches copy 0.
    a_r7_outputs_match: assert property (@(posedge clk) disable iff (!mrst_n)
        q == {NUM_OUT{q[0]}});

    // R6: reset pulls the outputs low at the next edge.
    a_r6_reset_low: assert property (@(posedge clk)
        !mrst_n |=> (q == '0));

    // R3 / R4 / R9: active exponent stays within 2..128.
    a_r9_exp_range: assert property (@(posedge clk) disable iff (!mrst_n)
        (exp_cur >= XW'(1)) && (int'(exp_cur) <= DIV_MAX));

    // R5 / R8: each finished phase lasted exactly half of its period.
    a_r5_phase_len: assert property (@(posedge clk) disable iff (!mrst_n)
        (armed && (q[0] != q_d)) |-> (run_len == phase_half));

endmodule

bind refclk_divpath refclk_divpath_chk #(
    .NUM_OUT (NUM_OUT),
    .XW      (XW),
    .DIV_MAX (DIV_MAX)
) u_chk (
    .clk     (div_clk),
    .mrst_n  (mrst_n),
    .q       (clk_out),
    .exp_cur (cfg_exp)
);

// File: tb/tb_refclk_divpath.sv
`timescale 1ns/1ps
// Bench: sweeps every code in both modes and with both references, then
// covers reset and a mid-period ratio change.
module tb_refclk_divpath;

    logic       ref0_clk = 1'b0;   // 125 MHz main clock
    logic       ref1_clk = 1'b0;
    logic       vco_clk  = 1'b0;
    logic       mrst_n   = 1'b0;
    logic       ref_sel  = 1'b0;
    logic       pll_en   = 1'b0;
    logic [3:0] div_code = 4'd0;
    logic [3:0] clk_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #4.0 ref0_clk = ~ref0_clk;
    always #6.0 ref1_clk = ~ref1_clk;
    always #2.0 vco_clk  = ~vco_clk;

    refclk_divpath dut (
        .ref0_clk (ref0_clk),
        .ref1_clk (ref1_clk),
        .vco_clk  (vco_clk),
        .mrst_n   (mrst_n),
        .ref_sel  (ref_sel),
        .pll_en   (pll_en),
        .div_code (div_code),
        .clk_out  (clk_out)
    );

    function automatic longint now_ps();
        return longint'($realtime * 1000.0);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stated bypass divide values.
    function automatic int bypass_div(input int c);
        case (c)
            0, 1, 2:   return 8;
            3, 4, 5:   return 16;
            6, 7:      return 32;
            8:         return 64;
            9:         return 128;
            10, 11, 14: return 4;
            12:        return 8;
            default:   return 2;
        endcase
    endfunction

    // VCO divider = (VCO multiple for the code's band) / (output ratio).
    function automatic int vco_div(input int c);
        int band_lg, ratio_lg;
        case (c)
            0, 4, 7, 9:    band_lg = 1;
            1, 5, 8, 10:   band_lg = 2;
            2, 6, 11, 13:  band_lg = 3;
            default:       band_lg = 4;
        endcase
        case (c)
            0, 1, 2, 3:    ratio_lg = 0;
            4, 5, 6:       ratio_lg = -1;
            7, 8:          ratio_lg = -2;
            9:             ratio_lg = -3;
            10, 11, 12:    ratio_lg = 1;
            13, 14:        ratio_lg = 2;
            default:       ratio_lg = 3;
        endcase
        return 1 << (band_lg - ratio_lg);
    endfunction

    // Skip the switching period, then time one full period and its high phase.
    task automatic measure(output longint per, output longint hi);
        longint t0, t1, t2;
        @(posedge clk_out[0]);
        @(posedge clk_out[0]);
        @(posedge clk_out[0]);
        t0 = now_ps();
        @(negedge clk_out[0]);
        t1 = now_ps();
        #0.1;
        check(clk_out == {4{clk_out[0]}}, "R7 copies after fall", longint'(clk_out), longint'({4{clk_out[0]}}));
        @(posedge clk_out[0]);
        t2 = now_ps();
        #0.1;
        check(clk_out == {4{clk_out[0]}}, "R7 copies after rise", longint'(clk_out), longint'({4{clk_out[0]}}));
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    initial begin
        #1200000.0;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        longint per, hi, t0, t1, t2, exp_per, src_ps;
        // R6: outputs low while reset is held.
        #50.3;
        for (int k = 0; k < 4; k++) begin
            check(clk_out == 4'b0000, "R6 low under reset", longint'(clk_out), 0);
            #3.3;
        end
        @(posedge ref0_clk);
        #1.0;
        mrst_n = 1'b1;
        t0 = now_ps();
        @(posedge clk_out[0]);
        check(now_ps() - t0 == 64'd7000, "R6 first rise on first edge", now_ps() - t0, 7000);

        // R1 R2 R3 R4 R5 R9: full sweep.
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int c = 0; c < 16; c++) begin
                    pll_en   = (m == 1);
                    ref_sel  = (r == 1);
                    div_code = 4'(c);
                    measure(per, hi);
                    if (m == 1) begin
                        exp_per = 4000 * vco_div(c);
                        check(per == exp_per, $sformatf("R4 R2 R9 vco period code %0d ref %0d", c, r), per, exp_per);
                    end else begin
                        src_ps  = (r == 1) ? 12000 : 8000;
                        exp_per = src_ps * bypass_div(c);
                        check(per == exp_per, $sformatf("R3 R1 R9 bypass period code %0d ref %0d", c, r), per, exp_per);
                    end
                    check(hi * 2 == per, $sformatf("R5 duty code %0d mode %0d", c, m), hi, per / 2);
                end
            end
        end

        // R8: change 128 -> 2 part-way through a high phase.
        pll_en   = 1'b0;
        ref_sel  = 1'b0;
        div_code = 4'd9;
        measure(per, hi);
        @(posedge clk_out[0]);
        t0 = now_ps();
        #100.0;
        div_code = 4'd13;
        check(clk_out[0] == 1'b1, "R8 old phase still high", longint'(clk_out[0]), 1);
        @(posedge clk_out[0]);
        t1 = now_ps();
        check(t1 - t0 == 64'd1024000, "R8 old period kept", t1 - t0, 1024000);
        @(negedge clk_out[0]);
        check(now_ps() - t1 == 64'd8000, "R8 new high phase", now_ps() - t1, 8000);
        @(posedge clk_out[0]);
        t2 = now_ps();
        check(t2 - t1 == 64'd16000, "R8 new period", t2 - t1, 16000);

        // R6: reset in the middle of running.
        #3.0;
        mrst_n = 1'b0;
        #20.3;
        for (int k = 0; k < 5; k++) begin
            check(clk_out == 4'b0000, "R6 low after mid-run reset", longint'(clk_out), 0);
            #7.1;
        end
        mrst_n = 1'b1;
        measure(per, hi);
        check(per == 64'd16000, "R6 runs after release", per, 16000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule